// File: doc/BRIEF.md
# UART receiver with overrun detection

This block is the asynchronous receive path of a serial port. It watches a single RX line, finds a start bit, and assembles a frame whose shape comes from the mode inputs: seven or eight data bits, optional parity (even or odd), and one or two stop bits. The bit time comes from the rate inputs. A finished byte lands in a one-entry receive data register, sets a full flag and, when receive interrupts are enabled, gives a one-cycle receive-full interrupt.

Error conditions are sticky flags: overrun when a byte completes while the previous one is still unread (the new byte is dropped), framing error when a stop bit is low (this includes a line break), and parity error when the parity bit disagrees with the data. Any set flag drives the receive-error interrupt as a level while receive interrupts are enabled. Software reads the byte with a read strobe and clears the error flags with a clear strobe. After every completed frame the receiver rests for one full frame time before it will look for another start bit.

Top module: `uart_rx_core`

## Requirements
- R1: After reset rx_full, all three error flags, rx_data and both interrupt outputs are 0.
- R2: While rx_en is 0 the line is ignored: no byte is loaded and no flag changes.
- R3: A frame is start (0), data bits LSB first, then stop (1); a good frame loads rx_data, sets rx_full and, if rx_ie is 1, pulses irq_rxfull high for exactly one cycle; rd_ack clears rx_full.
- R4: With cfg_seven set, seven data bits are taken and rx_data[7] reads 0.
- R5: With cfg_parity set a parity bit follows the data; cfg_odd=0 selects even parity (data bits plus parity bit hold an even number of ones), cfg_odd=1 odd; a mismatch sets err_parity and the byte is still delivered.
- R6: A low stop bit sets err_frame and the byte is not delivered; with cfg_two_stop set the second stop bit is checked as well.
- R7: A line break (start, all data bits, parity and stop all low) sets err_frame and leaves rx_full and rx_data unchanged.
- R8: If rx_full is still 1 when a good frame completes, the byte is discarded, rx_data keeps the old byte and err_overrun is set.
- R9: irq_rxerr is high whenever rx_ie is 1 and any error flag is set; with rx_ie 0 neither interrupt is raised; clr_err clears all error flags.
- R10: After a frame completes no start bit is accepted until one full frame time (frame bits times bit time) has passed.
- R11: A low pulse shorter than half a bit time is rejected as a start bit.
- R12: The bit time is (cfg_baud+1) * 4^cfg_presc clock cycles, and the start bit is confirmed at mid-bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pin | input | 1 | Asynchronous serial input, idle high |
| rx_en | input | 1 | Receive enable |
| rx_ie | input | 1 | Receive interrupt enable |
| cfg_seven | input | 1 | 1: seven data bits, 0: eight |
| cfg_parity | input | 1 | Parity bit present |
| cfg_odd | input | 1 | 1: odd parity, 0: even |
| cfg_two_stop | input | 1 | Two stop bits |
| cfg_presc | input | 2 | Prescale exponent, factor 4^n |
| cfg_baud | input | BAUD_W | Bit-rate divisor minus one |
| rd_ack | input | 1 | Read strobe, clears rx_full |
| clr_err | input | 1 | Clears all error flags |
| rx_data | output | 8 | Receive data register |
| rx_full | output | 1 | Receive data register holds an unread byte |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| irq_rxfull | output | 1 | Receive-full interrupt, one-cycle pulse |
| irq_rxerr | output | 1 | Receive-error interrupt, level |

## Verification
The bench aims at the points where a receiver quietly goes wrong: a second byte arriving while the first is unread, which a faulty design would overwrite instead of dropping while flagging overrun; a break, which a design without a stop check would hand up as a 0x00 byte; and seven-bit mode, where taking one bit too many would place the stop bit into bit 7. It also sends a frame immediately behind another, which a receiver without the rest period would accept, and a short low glitch, which a receiver that trusts the falling edge without a mid-bit recheck would turn into a bogus byte. A rate test with a non-zero prescaler catches a wrong scaling of the bit time, since every data bit would then be sampled at the wrong place.

// File: rtl/uart_rx_core.sv
module uart_rx_core #(
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_pin,
  input  logic              rx_en,
  input  logic              rx_ie,
  input  logic              cfg_seven,
  input  logic              cfg_parity,
  input  logic              cfg_odd,
  input  logic              cfg_two_stop,
  input  logic [1:0]        cfg_presc,
  input  logic [BAUD_W-1:0] cfg_baud,
  input  logic              rd_ack,
  input  logic              clr_err,
  output logic [7:0]        rx_data,
  output logic              rx_full,
  output logic              err_overrun,
  output logic              err_frame,
  output logic              err_parity,
  output logic              irq_rxfull,
  output logic              irq_rxerr
);

  localparam int TW = BAUD_W + 7;
  localparam int HW = TW + 4;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  logic [1:0]    sync_q;
  logic          rx_s;
  st_t           st;
  logic [TW-1:0] tick, bit_len;
  logic [TW-1:0] bit_len_in;
  logic [3:0]    frame_len_in, frame_len;
  logic [HW-1:0] hold;
  logic [2:0]    idx;
  logic [7:0]    sh;
  logic          par_acc, pbit_q, stop_bad, stop_idx;
  logic          seven_q, pen_q, odd_q, two_q;
  logic          tick_done, bad_now;

  assign rx_s         = sync_q[1];
  assign tick_done    = (tick == '0);
  assign bad_now      = stop_bad | ~rx_s;
  assign bit_len_in   = (TW'(cfg_baud) + TW'(1)) << {cfg_presc, 1'b0};
  assign frame_len_in = 4'd1 + (cfg_seven ? 4'd7 : 4'd8) + {3'b000, cfg_parity}
                        + (cfg_two_stop ? 4'd2 : 4'd1);
  assign irq_rxerr    = rx_ie & (err_overrun | err_frame | err_parity);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_pin};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      tick        <= '0;
      bit_len     <= '0;
      frame_len   <= '0;
      hold        <= '0;
      idx         <= '0;
      sh          <= '0;
      par_acc     <= 1'b0;
      pbit_q      <= 1'b0;
      stop_bad    <= 1'b0;
      stop_idx    <= 1'b0;
      seven_q     <= 1'b0;
      pen_q       <= 1'b0;
      odd_q       <= 1'b0;
      two_q       <= 1'b0;
      rx_data     <= '0;
      rx_full     <= 1'b0;
      err_overrun <= 1'b0;
      err_frame   <= 1'b0;
      err_parity  <= 1'b0;
      irq_rxfull  <= 1'b0;
    end else begin
      irq_rxfull <= 1'b0;
      if (rd_ack) rx_full <= 1'b0;
      if (clr_err) begin
        err_overrun <= 1'b0;
        err_frame   <= 1'b0;
        err_parity  <= 1'b0;
      end
      if (hold != '0) hold <= hold - HW'(1);

      if (!rx_en) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            if (hold == '0 && !rx_s) begin
              st        <= S_START;
              tick      <= bit_len_in >> 1;
              bit_len   <= bit_len_in;
              frame_len <= frame_len_in;
              seven_q   <= cfg_seven;
              pen_q     <= cfg_parity;
              odd_q     <= cfg_odd;
              two_q     <= cfg_two_stop;
            end
          end
          S_START: begin
            if (!tick_done) begin
              tick <= tick - TW'(1);
            end else if (!rx_s) begin
              st       <= S_DATA;
              tick     <= bit_len - TW'(1);
              idx      <= '0;
              sh       <= '0;
              par_acc  <= 1'b0;
              stop_bad <= 1'b0;
              stop_idx <= 1'b0;
            end else begin
              st <= S_IDLE;
            end
          end
          S_DATA: begin
            if (!tick_done) begin
              tick <= tick - TW'(1);
            end else begin
              sh      <= {rx_s, sh[7:1]};
              par_acc <= par_acc ^ rx_s;
              tick    <= bit_len - TW'(1);
              idx     <= idx + 3'd1;
              if (idx == (seven_q ? 3'd6 : 3'd7))
                st <= pen_q ? S_PAR : S_STOP;
            end
          end
          S_PAR: begin
            if (!tick_done) begin
              tick <= tick - TW'(1);
            end else begin
              pbit_q <= rx_s;
              tick   <= bit_len - TW'(1);
              st     <= S_STOP;
            end
          end
          S_STOP: begin
            if (!tick_done) begin
              tick <= tick - TW'(1);
            end else if (two_q && !stop_idx) begin
              stop_idx <= 1'b1;
              stop_bad <= bad_now;
              tick     <= bit_len - TW'(1);
            end else begin
              st   <= S_IDLE;
              hold <= HW'(frame_len) * HW'(bit_len);
              if (bad_now) begin
                err_frame <= 1'b1;
              end else if (rx_full) begin
                err_overrun <= 1'b1;
              end else begin
                rx_data    <= seven_q ? {1'b0, sh[7:1]} : sh;
                rx_full    <= 1'b1;
                irq_rxfull <= rx_ie;
                if (pen_q && (par_acc ^ pbit_q ^ odd_q)) err_parity <= 1'b1;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_RXFULL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxfull |=> !irq_rxfull); // R3
  AST_PULSE_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rxfull |-> rx_full && $past(rx_ie)); // R3
  AST_HELD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |=> $stable(rx_data)); // R8
  AST_OVR_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> $past(rx_full)); // R8
  AST_OFF_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> st == S_IDLE); // R2
  AST_REST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (hold != '0) |-> st == S_IDLE); // R10

endmodule

// File: tb/test_uart_rx_core.sv
`timescale 1ns/1ps
module test_uart_rx_core;
  logic clk = 1'b0, rst_n = 1'b0, rx_pin = 1'b1;
  logic rx_en = 1'b0, rx_ie = 1'b1, cfg_seven = 1'b0, cfg_parity = 1'b0;
  logic cfg_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [1:0] cfg_presc = 2'd0;
  logic [7:0] cfg_baud = 8'd7;
  logic rd_ack = 1'b0, clr_err = 1'b0;
  logic [7:0] rx_data;
  logic rx_full, err_overrun, err_frame, err_parity, irq_rxfull, irq_rxerr;
  int checks = 0, fails = 0, pulses = 0, bc = 8;

  always #2.5 clk = ~clk;

  uart_rx_core #(.BAUD_W(8)) i_uart_rx_core (
    .clk(clk), .rst_n(rst_n), .rx_pin(rx_pin), .rx_en(rx_en), .rx_ie(rx_ie),
    .cfg_seven(cfg_seven), .cfg_parity(cfg_parity), .cfg_odd(cfg_odd),
    .cfg_two_stop(cfg_two_stop), .cfg_presc(cfg_presc), .cfg_baud(cfg_baud),
    .rd_ack(rd_ack), .clr_err(clr_err), .rx_data(rx_data), .rx_full(rx_full),
    .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
    .irq_rxfull(irq_rxfull), .irq_rxerr(irq_rxerr));

  always @(posedge clk) if (irq_rxfull) pulses++;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    rx_pin = b;
    repeat (bc) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nd, input bit pen,
                            input bit pb, input bit s1, input bit two, input bit s2);
    drive_bit(1'b0);
    for (int i = 0; i < nd; i++) drive_bit(d[i]);
    if (pen) drive_bit(pb);
    drive_bit(s1);
    if (two) drive_bit(s2);
    rx_pin = 1'b1;
  endtask

  task automatic settle();
    repeat (2 * bc) @(negedge clk);
  endtask

  task automatic rest();
    repeat (14 * bc) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_ack = 1'b1; @(negedge clk); rd_ack = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_clr();
    clr_err = 1'b1; @(negedge clk); clr_err = 1'b0; @(negedge clk);
  endtask

  function automatic bit even_par(input logic [7:0] d, input int nd);
    bit p = 1'b0;
    for (int i = 0; i < nd; i++) p ^= d[i];
    return p;
  endfunction

  task automatic t_reset();
    check("R1 rx_full", rx_full, 0);
    check("R1 flags", {err_overrun, err_frame, err_parity}, 0);
    check("R1 irqs", {irq_rxfull, irq_rxerr}, 0);
    check("R1 rx_data", rx_data, 0);
  endtask

  task automatic t_disabled();
    int p0 = pulses;
    rx_en = 1'b0;
    send_frame(8'h3C, 8, 0, 0, 1, 0, 1); settle();
    check("R2 rx_full while off", rx_full, 0);
    check("R2 no pulse while off", pulses - p0, 0);
    check("R2 flags while off", {err_overrun, err_frame, err_parity}, 0);
    rx_en = 1'b1; rest();
  endtask

  task automatic t_basic();
    int p0 = pulses;
    send_frame(8'hA5, 8, 0, 0, 1, 0, 1); settle();
    check("R3 data", rx_data, 8'hA5);
    check("R3 rx_full", rx_full, 1);
    check("R3 one pulse", pulses - p0, 1);
    pulse_rd();
    check("R3 rd clears full", rx_full, 0);
    rest();
  endtask

  task automatic t_seven();
    cfg_seven = 1'b1;
    send_frame(8'h2B, 7, 0, 0, 1, 0, 1); settle();
    check("R4 seven-bit data", rx_data, 8'h2B);
    pulse_rd(); rest();
    cfg_seven = 1'b0;
  endtask

  task automatic t_parity();
    cfg_parity = 1'b1; cfg_odd = 1'b0;
    send_frame(8'h03, 8, 1, even_par(8'h03, 8), 1, 0, 1); settle();
    check("R5 even ok data", rx_data, 8'h03);
    check("R5 even ok flag", err_parity, 0);
    pulse_rd(); rest();
    send_frame(8'h01, 8, 1, 1'b0, 1, 0, 1); settle();
    check("R5 even bad flag", err_parity, 1);
    check("R5 byte still delivered", {rx_full, rx_data}, {1'b1, 8'h01});
    pulse_rd(); pulse_clr(); rest();
    cfg_odd = 1'b1;
    send_frame(8'h01, 8, 1, 1'b0, 1, 0, 1); settle();
    check("R5 odd ok flag", err_parity, 0);
    pulse_rd(); rest();
    cfg_parity = 1'b0; cfg_odd = 1'b0;
  endtask

  task automatic t_frame();
    send_frame(8'h81, 8, 0, 0, 0, 0, 1); settle();
    check("R6 frame flag", err_frame, 1);
    check("R6 no byte", rx_full, 0);
    check("R9 err irq level", irq_rxerr, 1);
    pulse_clr();
    check("R9 clear flags", {err_overrun, err_frame, err_parity, irq_rxerr}, 0);
    rest();
    cfg_two_stop = 1'b1;
    send_frame(8'h42, 8, 0, 0, 1, 1, 0); settle();
    check("R6 second stop low", {err_frame, rx_full}, 2'b10);
    pulse_clr(); rest();
    cfg_two_stop = 1'b0;
  endtask

  task automatic t_break();
    logic [7:0] old = rx_data;
    cfg_parity = 1'b1;
    send_frame(8'h00, 8, 1, 0, 0, 0, 0); settle();
    check("R7 break frame flag", err_frame, 1);
    check("R7 break no load", {rx_full, rx_data}, {1'b0, old});
    pulse_clr(); rest();
    cfg_parity = 1'b0;
  endtask

  task automatic t_overrun();
    send_frame(8'h11, 8, 0, 0, 1, 0, 1); settle(); rest();
    send_frame(8'h22, 8, 0, 0, 1, 0, 1); settle();
    check("R8 overrun flag", err_overrun, 1);
    check("R8 old byte kept", {rx_full, rx_data}, {1'b1, 8'h11});
    check("R9 overrun irq", irq_rxerr, 1);
    pulse_rd(); pulse_clr(); rest();
  endtask

  task automatic t_masked();
    int p0 = pulses;
    rx_ie = 1'b0;
    send_frame(8'h44, 8, 0, 0, 1, 0, 1); settle();
    check("R9 masked: byte loaded", {rx_full, rx_data}, {1'b1, 8'h44});
    check("R9 masked: no pulse", pulses - p0, 0);
    rest();
    send_frame(8'h55, 8, 0, 0, 1, 0, 1); settle();
    check("R9 masked: flag without irq", {err_overrun, irq_rxerr}, 2'b10);
    pulse_rd(); pulse_clr(); rest();
    rx_ie = 1'b1;
  endtask

  task automatic t_rest_period();
    int p0 = pulses;
    send_frame(8'h3C, 8, 0, 0, 1, 0, 1);
    send_frame(8'h5A, 8, 0, 0, 1, 0, 1); settle();
    check("R10 second frame ignored", pulses - p0, 1);
    check("R10 no overrun", {err_overrun, rx_data}, {1'b0, 8'h3C});
    pulse_rd(); rest();
    send_frame(8'h99, 8, 0, 0, 1, 0, 1); settle();
    check("R10 accepted after rest", {rx_full, rx_data}, {1'b1, 8'h99});
    pulse_rd(); rest();
  endtask

  task automatic t_glitch();
    int p0 = pulses;
    rx_pin = 1'b0; repeat (2) @(negedge clk); rx_pin = 1'b1;
    repeat (12 * bc) @(negedge clk);
    check("R11 glitch rejected", {rx_full, err_frame}, 0);
    check("R11 no pulse", pulses - p0, 0);
    rest();
  endtask

  task automatic t_rate();
    cfg_presc = 2'd1; cfg_baud = 8'd3; bc = 16;
    send_frame(8'hC6, 8, 0, 0, 1, 0, 1); settle();
    check("R12 prescaled rate data", {rx_full, rx_data}, {1'b1, 8'hC6});
    pulse_rd(); rest();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled();
    t_basic();
    t_seven();
    t_parity();
    t_frame();
    t_break();
    t_overrun();
    t_masked();
    t_rest_period();
    t_glitch();
    t_rate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule